// File: doc/BRIEF.md
# Prioritised interrupt router with claim and complete

This block gathers a parameterised set of external interrupt lines, numbered from 1 upward, and steers them to a small number of target contexts. Each line passes through its own gateway. A gateway is either level-high or rising-edge, chosen by a parameter bit for that source. The gateway turns activity on the line into a pending bit. It then holds the source locked from the moment a context claims it until that context reports completion.

Each source carries a small priority. Each context holds a per-source enable mask, a threshold and a claim/complete register. A context asserts its request line while at least one pending source that it has enabled has a priority strictly above its threshold. Software reads the context's claim register to take the best candidate. That read clears the source's pending bit in the same cycle. When handling is done, software writes the same ID back to the register.

Registers sit on a simple single-cycle bus. Read data is combinational from the address while the read enable is high. Writes take effect at the clock edge. The asynchronous active-low reset is released through a two-stage synchroniser. Interrupt lines are assumed to be synchronous to the clock already.

Top module: `intc_core`

## Requirements
- R1: After reset every request line is low, every priority, enable and threshold register reads 0, and every claim register reads 0.
- R2: The priority of source s sits at byte address 4*s and holds 3 bits in bits 2:0. Upper write bits are dropped and read back as 0. Address 0 (source 0) always reads 0, and writes to it have no effect.
- R3: The enable mask of context c is at 0x2000 + 0x80*c. Source s is bit (s mod 32) of the word at offset 4*(s div 32). Bit 0 of word 0 (source 0) always reads 0.
- R4: The threshold of context c is at 0x200000 + 0x1000*c, in bits 2:0. Request line c is high exactly when some pending source enabled for c has a priority strictly greater than that threshold. A threshold of 7 holds the line low.
- R5: Reading the claim register at 0x200004 + 0x1000*c returns the eligible source with the highest priority. Among sources of equal priority, the lowest ID wins. The read returns 0 when no source is eligible.
- R6: A claim read clears the returned source's pending bit. Until that source is completed, it cannot become pending again, even if its line stays high or pulses again.
- R7: Writing a source ID to a context's claim register completes that source. A level source whose line is still high is pending again on the following cycle.
- R8: A completion write is ignored when the ID is 0, when it is above the source count, or when the source is not enabled for the context that is written.
- R9: An edge source becomes pending on a rising edge of its line and stays pending after the line falls. A level source whose line is low is never pending.
- R10: A source with priority 0 never raises a request and is never returned by a claim, even when it is pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt lines; bit s is source s (1..NUM_SRC) |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write enable, taken at the clock edge |
| bus_re_i | input | 1 | Read enable; a read of a claim register also takes the source |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as bus_re_i |
| irq_o | output | NUM_CTX | Request line for each context |

## Verification
Two events can meet at one source's gateway in the same cycle. One is a completion write. The other is a line that is still asserted, which a level gateway must turn back into a new pending bit straight after the lock drops. The bench provokes this by completing a level source while its line is held high. It then claims again at once and expects that same ID back. Before the completion, it writes completions that must be ignored (an ID that is not enabled, an ID out of range, and a write to the wrong context). Each of these must leave the claim register at 0. A second case sends a rising edge on an edge source while the source is locked. The bench judges it by an empty claim after completion, followed by a normal claim once a fresh edge arrives.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam int          EN_SHIFT   = 7;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
  localparam int          CTX_SHIFT  = 12;
  localparam logic [31:0] OFS_THR    = 32'h0;
  localparam logic [31:0] OFS_CLAIM  = 32'h4;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PRIO,
    ACC_EN,
    ACC_THR,
    ACC_CLAIM
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [7:0] ctx;
    logic [9:0] idx;
  } acc_t;

endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_no = s2_q;

endmodule

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_t              acc_o
);

  localparam logic [31:0] PRIO_END = 32'(4 * (NUM_SRC + 1));
  localparam logic [31:0] EN_END   = EN_BASE + 32'(NUM_CTX) * EN_STRIDE;
  localparam logic [31:0] CTX_END  = CTX_BASE + 32'(NUM_CTX) * CTX_STRIDE;

  logic [31:0] a32;
  assign a32 = 32'(addr_i);

  always_comb begin
    acc_o = '{kind: ACC_NONE, ctx: '0, idx: '0};
    if (a32 < PRIO_END) begin
      acc_o.kind = ACC_PRIO;
      acc_o.idx  = 10'(a32 >> 2);
    end else if (a32 >= EN_BASE && a32 < EN_END) begin
      acc_o.kind = ACC_EN;
      acc_o.ctx  = 8'((a32 - EN_BASE) >> EN_SHIFT);
      acc_o.idx  = 10'(((a32 - EN_BASE) & (EN_STRIDE - 1)) >> 2);
    end else if (a32 >= CTX_BASE && a32 < CTX_END) begin
      acc_o.ctx = 8'((a32 - CTX_BASE) >> CTX_SHIFT);
      if (((a32 - CTX_BASE) & (CTX_STRIDE - 1)) == OFS_THR)
        acc_o.kind = ACC_THR;
      else if (((a32 - CTX_BASE) & (CTX_STRIDE - 1)) == OFS_CLAIM)
        acc_o.kind = ACC_CLAIM;
    end
  end

endmodule

// File: rtl/intc_gate.sv
module intc_gate #(
  parameter bit IS_EDGE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o,
  output logic busy_o
);

  logic trig;
  logic pend_q, pend_d, busy_q, busy_d;

  if (IS_EDGE) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= line_i;
    end
    assign trig = line_i & ~prev_q;
  end else begin : g_level
    assign trig = line_i;
  end

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    if (done_i) busy_d = 1'b0;
    if (claim_i) begin
      pend_d = 1'b0;
      busy_d = 1'b1;
    end else if (trig && !busy_q && !pend_q) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;

endmodule

// File: rtl/intc_select.sv
module intc_select #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int SW      = 5
) (
  input  logic [NUM_SRC:1]             elig_i,
  input  logic [NUM_SRC:1][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]            thr_i,
  output logic [SW-1:0]                win_o,
  output logic                         req_o
);

  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_p = thr_i;
    win_o  = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      if (elig_i[s] && prio_i[s] > best_p) begin
        best_p = prio_i[s];
        win_o  = SW'(s);
      end
    end
  end

  assign req_o = (win_o != '0);

endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int               NUM_SRC  = 31,
  parameter int               NUM_CTX  = 2,
  parameter int               PRIO_W   = 3,
  parameter int               ADDR_W   = 24,
  parameter logic [NUM_SRC:0] EDGE_SRC = 'h0F00
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC:1]    src_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  input  logic                bus_we_i,
  input  logic                bus_re_i,
  output logic [31:0]         bus_rdata_o,
  output logic [NUM_CTX-1:0]  irq_o
);

  localparam int SW = $clog2(NUM_SRC + 1);

  logic rst_n;
  acc_t acc;

  logic [NUM_SRC:1][PRIO_W-1:0]  prio_q, prio_d;
  logic [NUM_CTX-1:0][NUM_SRC:1] en_q, en_d;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q, thr_d;
  logic                          cfg_we;

  logic [NUM_SRC:1] pend, busy, claim_vec, done_vec;
  logic [NUM_CTX-1:0]         clm_rd, cpl_wr;
  logic [NUM_CTX-1:0][SW-1:0] win_id;

  intc_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  intc_decode #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_dec (
    .addr_i(bus_addr_i),
    .acc_o (acc)
  );

  // configuration registers: next state
  assign cfg_we = bus_we_i &&
                  (acc.kind == ACC_PRIO || acc.kind == ACC_EN || acc.kind == ACC_THR);

  always_comb begin
    prio_d = prio_q;
    en_d   = en_q;
    thr_d  = thr_q;
    case (acc.kind)
      ACC_PRIO: begin
        for (int s = 1; s <= NUM_SRC; s++)
          if (acc.idx == 10'(s)) prio_d[s] = bus_wdata_i[PRIO_W-1:0];
      end
      ACC_EN: begin
        for (int c = 0; c < NUM_CTX; c++)
          for (int s = 1; s <= NUM_SRC; s++)
            if (acc.ctx == 8'(c) && acc.idx == 10'(s / 32))
              en_d[c][s] = bus_wdata_i[s % 32];
      end
      ACC_THR: begin
        for (int c = 0; c < NUM_CTX; c++)
          if (acc.ctx == 8'(c)) thr_d[c] = bus_wdata_i[PRIO_W-1:0];
      end
      default: ;
    endcase
  end

  // configuration registers: state
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (cfg_we) begin
      prio_q <= prio_d;
      en_q   <= en_d;
      thr_q  <= thr_d;
    end
  end

  // gateways, one per source
  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    intc_gate #(.IS_EDGE(EDGE_SRC[s])) u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .line_i (src_i[s]),
      .claim_i(claim_vec[s]),
      .done_i (done_vec[s]),
      .pend_o (pend[s]),
      .busy_o (busy[s])
    );
  end

  // per-context selection
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    intc_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SW(SW)) u_sel (
      .elig_i(pend & en_q[c]),
      .prio_i(prio_q),
      .thr_i (thr_q[c]),
      .win_o (win_id[c]),
      .req_o (irq_o[c])
    );
    assign clm_rd[c] = bus_re_i && acc.kind == ACC_CLAIM && acc.ctx == 8'(c);
    assign cpl_wr[c] = bus_we_i && acc.kind == ACC_CLAIM && acc.ctx == 8'(c);
  end

  // claim and completion routing to gateways
  always_comb begin
    claim_vec = '0;
    done_vec  = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      for (int c = 0; c < NUM_CTX; c++) begin
        if (clm_rd[c] && win_id[c] == SW'(s)) claim_vec[s] = 1'b1;
        if (cpl_wr[c] && bus_wdata_i == 32'(s) && en_q[c][s]) done_vec[s] = 1'b1;
      end
    end
  end

  // read data
  always_comb begin
    bus_rdata_o = '0;
    if (bus_re_i) begin
      case (acc.kind)
        ACC_PRIO: begin
          for (int s = 1; s <= NUM_SRC; s++)
            if (acc.idx == 10'(s)) bus_rdata_o = 32'(prio_q[s]);
        end
        ACC_EN: begin
          for (int c = 0; c < NUM_CTX; c++)
            for (int s = 1; s <= NUM_SRC; s++)
              if (acc.ctx == 8'(c) && acc.idx == 10'(s / 32))
                bus_rdata_o[s % 32] = en_q[c][s];
        end
        ACC_THR: begin
          for (int c = 0; c < NUM_CTX; c++)
            if (acc.ctx == 8'(c)) bus_rdata_o = 32'(thr_q[c]);
        end
        ACC_CLAIM: begin
          for (int c = 0; c < NUM_CTX; c++)
            if (clm_rd[c]) bus_rdata_o = 32'(win_id[c]);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24
) (
  input logic                           clk_i,
  input logic                           rst_n,
  input logic [ADDR_W-1:0]              bus_addr_i,
  input logic                           bus_re_i,
  input logic [31:0]                    bus_rdata_o,
  input logic [NUM_CTX-1:0]             irq_o,
  input logic [NUM_SRC:1]               pend,
  input logic [NUM_SRC:1]               busy,
  input logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q
);

  localparam int SW = $clog2(NUM_SRC + 1);

  logic [NUM_CTX-1:0] hit;
  always_comb
    for (int c = 0; c < NUM_CTX; c++)
      hit[c] = bus_re_i &&
               (32'(bus_addr_i) == CTX_BASE + 32'(c) * CTX_STRIDE + OFS_CLAIM);

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_c
    p_claim_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
      (hit[c] && !irq_o[c]) |-> bus_rdata_o == 32'h0);

    p_claim_locks_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
      (hit[c] && bus_rdata_o != 32'h0) |=>
        (!pend[$past(bus_rdata_o[SW-1:0])] && busy[$past(bus_rdata_o[SW-1:0])]));

    p_irq_has_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
      irq_o[c] |-> (pend != '0));

    p_thr_max_masks_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
      (thr_q[c] == {PRIO_W{1'b1}}) |-> !irq_o[c]);
  end

  p_prio_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_re_i && 32'(bus_addr_i) < 32'(4 * (NUM_SRC + 1))) |->
      bus_rdata_o[31:PRIO_W] == '0);

  p_pend_busy_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pend & busy) == '0);

endmodule

bind intc_core intc_core_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .bus_addr_i (bus_addr_i),
  .bus_re_i   (bus_re_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_o      (irq_o),
  .pend       (pend),
  .busy       (busy),
  .thr_q      (thr_q)
);

// File: tb/intc_core_tb_top.sv
`timescale 1ns/1ps
module intc_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:1] src;
  logic [23:0] addr;
  logic [31:0] wdata, rdata;
  logic        we, re;
  logic [1:0]  irq;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  intc_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we), .bus_re_i(re),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [23:0] a_prio(int s); return 24'(4 * s); endfunction
  function automatic logic [23:0] a_en(int c);   return 24'(32'h2000 + 32'h80 * c); endfunction
  function automatic logic [23:0] a_thr(int c);  return 24'(32'h20_0000 + 32'h1000 * c); endfunction
  function automatic logic [23:0] a_clm(int c);  return 24'(32'h20_0004 + 32'h1000 * c); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [23:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [23:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #2 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic line(int s, logic v);
    @(negedge clk); src[s] = v;
    @(negedge clk);
  endtask

  task automatic pulse(int s);
    @(negedge clk); src[s] = 1'b1;
    @(negedge clk); src[s] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq), 32'h0);
    rd(a_prio(5), d); check("R1 prio", d, 0);
    rd(a_en(0), d);   check("R1 enable", d, 0);
    rd(a_thr(1), d);  check("R1 threshold", d, 0);
    rd(a_clm(0), d);  check("R1 claim", d, 0);
  endtask

  task automatic t_prio_regs();
    logic [31:0] d;
    wr(a_prio(3), 32'hFFFF_FFFD); rd(a_prio(3), d); check("R2 3-bit priority", d, 5);
    wr(a_prio(0), 7);             rd(a_prio(0), d); check("R2 source 0", d, 0);
  endtask

  task automatic t_enable_regs();
    logic [31:0] d;
    wr(a_en(0), 32'hFFFF_FFFF); rd(a_en(0), d); check("R3 bit0 hardwired", d, 32'hFFFF_FFFE);
    wr(a_en(1), 32'h10);        rd(a_en(1), d); check("R3 ctx1 word", d, 32'h10);
    rd(a_en(0), d);                             check("R3 ctx0 untouched", d, 32'hFFFF_FFFE);
    wr(a_en(0), 0); wr(a_en(1), 0);
  endtask

  task automatic t_threshold();
    wr(a_prio(3), 5); wr(a_en(0), 32'h8); wr(a_thr(0), 5);
    line(3, 1'b1);
    check("R4 equal to threshold", 32'(irq[0]), 0);
    check("R4 other ctx", 32'(irq[1]), 0);
    wr(a_thr(0), 4); check("R4 above threshold", 32'(irq[0]), 1);
    wr(a_thr(0), 7); check("R4 threshold 7", 32'(irq[0]), 0);
    wr(a_thr(0), 0); check("R4 threshold 0", 32'(irq[0]), 1);
  endtask

  task automatic t_arbitrate();
    logic [31:0] d;
    wr(a_prio(4), 6); wr(a_prio(6), 6); wr(a_en(0), 32'h58);
    line(6, 1'b1); line(4, 1'b1);
    rd(a_clm(0), d); check("R5 tie lowest id", d, 4);
    rd(a_clm(0), d); check("R6 locked, next", d, 6);
    rd(a_clm(0), d); check("R5 lower prio", d, 3);
    rd(a_clm(0), d); check("R5 empty claim", d, 0);
    check("R6 irq low while locked", 32'(irq[0]), 0);
    wr(a_clm(0), 20); wr(a_clm(0), 40); wr(a_clm(1), 4);
    rd(a_clm(0), d); check("R8 bad completions ignored", d, 0);
    wr(a_clm(0), 4);
    rd(a_clm(0), d); check("R7 level re-pends", d, 4);
    @(negedge clk); src[3] = 0; src[4] = 0; src[6] = 0;
    wr(a_clm(0), 3); wr(a_clm(0), 4); wr(a_clm(0), 6);
    rd(a_clm(0), d); check("R9 low level not pending", d, 0);
    check("R9 irq idle", 32'(irq[0]), 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(a_prio(9), 2); wr(a_en(1), 32'h200);
    pulse(9);
    check("R9 edge latched", 32'(irq[1]), 1);
    rd(a_clm(1), d); check("R9 edge claim", d, 9);
    check("R6 cleared by claim", 32'(irq[1]), 0);
    pulse(9);
    wr(a_clm(1), 9);
    repeat (2) @(negedge clk);
    rd(a_clm(1), d); check("R6 edge during lock dropped", d, 0);
    pulse(9);
    rd(a_clm(1), d); check("R7 reopened edge", d, 9);
    wr(a_clm(1), 9);
  endtask

  task automatic t_prio_zero();
    logic [31:0] d;
    wr(a_en(0), 32'h1000); wr(a_prio(12), 0);
    line(12, 1'b1);
    check("R10 prio 0 irq", 32'(irq[0]), 0);
    rd(a_clm(0), d); check("R10 prio 0 claim", d, 0);
    wr(a_prio(12), 1);
    check("R10 prio 1 irq", 32'(irq[0]), 1);
    rd(a_clm(0), d); check("R10 prio 1 claim", d, 12);
    @(negedge clk); src[12] = 0;
    wr(a_clm(0), 12);
  endtask

  initial begin
    rst_n = 1'b0; src = '0; addr = '0; wdata = '0; we = 1'b0; re = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_prio_regs();
    t_enable_regs();
    t_threshold();
    t_arbitrate();
    t_edge();
    t_prio_zero();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule